// File: doc/BRIEF.md
# Field-Aware Chroma Vertical Decimator

This block converts one chroma component from 4:2:2 to 4:2:0 sampling. It takes one 8-bit chroma sample per handshake and filters vertically across six consecutive lines of the same field. On every second line it emits the filtered, rounded and clipped result for each column. The six-tap coefficients depend on field parity: the bottom-field set is the top-field set in reverse order. Both sets sum to 64, so the filter has unity gain.

The source marks the first sample of each line with a line-start flag. It marks the first sample of each field with a field-start flag, which also counts as a line start, and gives the field parity with it. Earlier lines are held in five internal line buffers, one column per address. Near the top of a field, taps that would reach above the first line reuse the first line instead.

After the last active line, the source must send three more line pulses. These drain the pipeline. Their data enters the filter window but is never a window centre. A sub-resolution mode can be selected on a plain control pin. It discards bottom fields completely and also keeps only even columns.

Input and output are valid/ready streams. A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold its sample and flags stable while `in_valid` is high and `in_ready` is low. A pending output is held unchanged until `out_ready` is high. No sample is accepted while an output waits.

Top module: `cvd_chroma_decim`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `out_valid` is high and `out_ready` is low, `out_data` stays stable, `out_valid` stays high, and no input sample is accepted. No output is lost or duplicated when the sink stalls.
- R3: Line and column numbering:
  - An accepted sample with `in_sof`=1 is line 0, column 0 of a new field.
  - A sample with `in_sol`=1 starts the next line at column 0.
  - Other samples advance the column by one.
- R4: An output is produced only for accepted samples on odd line numbers of 3 or more. Each such sample yields one output, for the same column, carrying the filtered window of lines n-5 to n.
- R5: With `in_bot`=0 at field start (top field), the coefficients are -3, 13, 30, 24, 4, -4. They apply from the oldest line (n-5) to the current line (n).
- R6: With `in_bot`=1 (bottom field), the coefficients are -4, 4, 24, 30, 13, -3, in the same oldest-to-newest order.
- R7: Window lines with a negative line number use the value of line 0 at the same column.
- R8: The result is (sum + 32) shifted arithmetically right by 6, then clipped to the range 0 to 255.
- R9: A field of N active lines (N even) followed by three flush lines yields N/2 output lines. The last output line is produced on line N+1.
- R10: With `sif_en`=1, a bottom field produces no output.
- R11: With `sif_en`=1, only even columns produce output.
- R12: Columns at or beyond `MAX_W` are neither stored nor output.
- R13: An output appears in the cycle after the accepted sample that produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sif_en | input | 1 | Sub-resolution mode: drop bottom fields, keep even columns |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 8 | Chroma sample |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a field (also a line start) |
| in_bot | input | 1 | Field parity at field start: 0 top, 1 bottom |
| out_valid | output | 1 | Decimated sample valid |
| out_ready | input | 1 | Sink accepts the output |
| out_data | output | 8 | Decimated, rounded, clipped chroma sample |

## Verification
A wrong line counter shows up at once. `out_valid` pulses on the wrong lines, which is seen one cycle after the first misnumbered sample. An error in column addressing or in line-buffer chaining corrupts only values, not timing. It is first visible on line 3, the first output line, where the edge-replication window shows it. A wrong coefficient set, or a field parity held incorrectly, changes every output value of that field. Clipping faults appear only when chosen line patterns push the sum outside 0 to 255, so dedicated patterns drive both extremes.

// File: rtl/cvd_pkg.sv
`timescale 1ns/1ps
package cvd_pkg;
  localparam int NTAP = 6;
  localparam int CW   = 7;
  localparam int FRAC = 6;
  localparam int HALF = 1 << (FRAC - 1);
  localparam int SUMW = 8 + CW + 3;

  typedef logic [7:0] pix_t;

  // Coefficient for tap i (0 = oldest line). Bottom field mirrors top.
  function automatic logic signed [CW-1:0] tap_coef(input logic bot, input int i);
    int k;
    k = bot ? (NTAP - 1 - i) : i;
    case (k)
      0:       tap_coef = -7'sd3;
      1:       tap_coef = 7'sd13;
      2:       tap_coef = 7'sd30;
      3:       tap_coef = 7'sd24;
      4:       tap_coef = 7'sd4;
      default: tap_coef = -7'sd4;
    endcase
  endfunction
endpackage

// File: rtl/cvd_linebuf.sv
`timescale 1ns/1ps
module cvd_linebuf #(
  parameter int DEPTH = 360,
  parameter int AW    = 9,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [DEPTH];

  // Read returns the line stored before this write (older line).
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end
endmodule

// File: rtl/cvd_seq.sv
`timescale 1ns/1ps
module cvd_seq
  import cvd_pkg::*;
#(
  parameter int MAX_W = 360,
  parameter int LW    = 11,
  parameter int XW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          sol,
  input  logic          sof,
  input  logic          bot_in,
  input  logic          sif,
  output logic [LW-1:0] n_cur,
  output logic [XW-1:0] x_cur,
  output logic          bot_cur,
  output logic          col_ok,
  output logic          wr_en,
  output logic          emit,
  output logic [2:0]    lim
);
  logic [LW-1:0] n_q;
  logic [XW-1:0] x_q;
  logic          bot_q;

  always_comb begin
    n_cur   = sof ? '0 : (sol ? n_q + LW'(1) : n_q);
    x_cur   = (sof || sol) ? '0 : x_q;
    bot_cur = sof ? bot_in : bot_q;
    col_ok  = x_cur < XW'(MAX_W);
    wr_en   = acc && col_ok;
    emit    = acc && col_ok && n_cur[0] && (n_cur >= LW'(3))
              && !(sif && bot_cur) && !(sif && x_cur[0]);
    lim     = (n_cur >= LW'(NTAP - 1)) ? 3'(NTAP - 1) : n_cur[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      x_q   <= '0;
      bot_q <= 1'b0;
    end else if (acc) begin
      n_q   <= n_cur;
      bot_q <= bot_cur;
      x_q   <= col_ok ? x_cur + XW'(1) : x_cur;
    end
  end
endmodule

// File: rtl/cvd_vfilt.sv
`timescale 1ns/1ps
module cvd_vfilt
  import cvd_pkg::*;
(
  input  logic bot,
  input  pix_t win [NTAP],
  output pix_t res
);
  logic signed [SUMW-1:0] acc;
  logic signed [SUMW-1:0] rnd;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAP; i++) begin
      acc = acc + SUMW'($signed({1'b0, win[i]})) * SUMW'(tap_coef(bot, i));
    end
    rnd = (acc + SUMW'(HALF)) >>> FRAC;
    if (rnd < 0)        res = 8'd0;
    else if (rnd > 255) res = 8'd255;
    else                res = rnd[7:0];
  end
endmodule

// File: rtl/cvd_chroma_decim.sv
`timescale 1ns/1ps
module cvd_chroma_decim
  import cvd_pkg::*;
#(
  parameter int MAX_W     = 360,
  parameter int MAX_LINES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sif_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sol,
  input  logic       in_sof,
  input  logic       in_bot,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int XW   = $clog2(MAX_W + 1);
  localparam int LW   = $clog2(MAX_LINES + NTAP);
  localparam int HIST = NTAP - 1;

  logic          acc;
  logic [LW-1:0] n_cur;
  logic [XW-1:0] x_cur;
  logic          bot_cur, col_ok, wr_en, emit;
  logic [2:0]    lim;
  pix_t          lb_out [HIST];
  pix_t          win [NTAP];
  pix_t          fres;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  cvd_seq #(.MAX_W(MAX_W), .LW(LW), .XW(XW)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sol(in_sol), .sof(in_sof),
    .bot_in(in_bot), .sif(sif_en), .n_cur(n_cur), .x_cur(x_cur),
    .bot_cur(bot_cur), .col_ok(col_ok), .wr_en(wr_en), .emit(emit), .lim(lim)
  );

  // Chain of line buffers: buffer k holds line n-1-k at each column.
  for (genvar k = 0; k < HIST; k++) begin : g_lb
    pix_t lb_in;
    if (k == 0) begin : g_first
      assign lb_in = in_data;
    end else begin : g_next
      assign lb_in = lb_out[k-1];
    end
    cvd_linebuf #(.DEPTH(MAX_W), .AW(XW), .DW(8)) u_lb (
      .clk(clk), .wr_en(wr_en), .addr(x_cur), .din(lb_in), .dout(lb_out[k])
    );
  end

  // Window: win[0] oldest ... win[NTAP-1] current; clamp above line 0.
  always_comb begin
    int d;
    int s;
    for (int i = 0; i < NTAP; i++) begin
      d = NTAP - 1 - i;
      s = (d <= int'(lim)) ? d : int'(lim);
      win[i] = (s == 0) ? in_data : lb_out[(s == 0) ? 0 : s - 1];
    end
  end

  cvd_vfilt u_filt (.bot(bot_cur), .win(win), .res(fres));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= fres;
      end
    end
  end
endmodule

// File: rtl/cvd_chroma_decim_chk.sv
`timescale 1ns/1ps
module cvd_chroma_decim_chk #(
  parameter int LW = 11,
  parameter int XW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sif_en,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [LW-1:0] n_cur,
  input logic [XW-1:0] x_cur,
  input logic          bot_cur
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_even_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (!n_cur[0] || n_cur < LW'(3))) |=> !out_valid);

  p_sif_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sif_en && bot_cur) |=> !out_valid);

  p_sif_column_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sif_en && x_cur[0]) |=> !out_valid);
endmodule

bind cvd_chroma_decim cvd_chroma_decim_chk #(.LW(LW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sif_en(sif_en), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .n_cur(n_cur), .x_cur(x_cur), .bot_cur(bot_cur)
);

// File: tb/sim_cvd_chroma_decim.sv
`timescale 1ns/1ps
module sim_cvd_chroma_decim;
  localparam int MW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sif_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sol = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_bot = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int    checks = 0;
  int    errors = 0;
  int    n_out = 0;
  int    cyc = 0;
  bit    rdy_mode = 0;
  bit    done = 0;
  bit    lo_seen = 0;
  bit    hi_seen = 0;
  int    img [0:63][0:15];
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cvd_chroma_decim #(.MAX_W(MW), .MAX_LINES(64)) u0 (
    .clk(clk), .rst_n(rst_n), .sif_en(sif_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol), .in_sof(in_sof),
    .in_bot(in_bot), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int coef(bit bot, int i);
    int t[6] = '{-3, 13, 30, 24, 4, -4};
    return bot ? t[5 - i] : t[i];
  endfunction

  function automatic int ref_val(int n, int x, bit bot);
    int a = 0;
    int v;
    for (int i = 0; i < 6; i++) begin
      int r = n - 5 + i;
      if (r < 0) r = 0;
      a += coef(bot, i) * img[r][x];
    end
    v = (a + 32) >>> 6;
    if (v < 0) begin lo_seen = 1; v = 0; end
    if (v > 255) begin hi_seen = 1; v = 255; end
    return v;
  endfunction

  function automatic int pat(int id, int n, int x, bit bot);
    case (id)
      0: return (n * 37 + x * 11 + bot * 90) % 256;
      1: return $urandom_range(0, 255);
      2: return (n % 6 == 0 || n % 6 == 5) ? 255 : 0;
      default: return (n % 6 >= 1 && n % 6 <= 4) ? 255 : 0;
    endcase
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin : mon
    int e;
    string t;
    if (rst_n && out_valid && out_ready) begin
      n_out++;
      if (exp_q.size() == 0) chk(0, "R4 unexpected output", out_data, -1);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e[7:0], t, out_data, e);
      end
    end
  end

  // Sink ready pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = rdy_mode ? (cyc % 3 != 1) : 1'b1;
  end

  task automatic send(int d, bit sol, bit sof, bit bot, int n, int x, bit sif, string tag);
    bit em;
    @(posedge clk); #1;
    in_data = d[7:0]; in_sol = sol; in_sof = sof; in_bot = bot; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    if (x < MW) img[n][x] = d;
    em = (n % 2 == 1) && (n >= 3) && (x < MW) && !(sif && bot) && !(sif && (x % 2 == 1));
    if (em) begin
      exp_q.push_back(ref_val(n, x, bot));
      tag_q.push_back(n == 3 ? "R7" : tag);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (!rdy_mode) begin
      @(negedge clk);
      chk(out_valid == em, "R4 R13 output valid timing", out_valid, em);
    end
  endtask

  task automatic send_field(bit bot, bit sif, int nact, int width, int pid, string tag);
    int base = n_out;
    int cols = (width < MW) ? width : MW;
    int expn;
    sif_en = sif;
    if (sif) cols = (cols + 1) / 2;
    expn = (sif && bot) ? 0 : (nact / 2) * cols;
    for (int n = 0; n < nact + 3; n++)
      for (int x = 0; x < width; x++)
        send(pat(pid, n, x, bot), x == 0, (n == 0 && x == 0), bot, n, x, sif, tag);
    repeat (20) @(negedge clk);
    chk(n_out - base == expn, {"R3 R9 output count ", tag}, n_out - base, expn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    send_field(0, 0, 8, 6, 0, "R5");      // top field
    send_field(1, 0, 8, 6, 0, "R6");      // bottom field
    send_field(0, 0, 6, 4, 2, "R8");      // drives low clip
    send_field(0, 0, 6, 4, 3, "R8");      // drives high clip
    send_field(1, 0, 10, 5, 1, "R6");     // random bottom
    rdy_mode = 1;
    send_field(0, 0, 8, 8, 1, "R2");      // back-pressure
    send_field(1, 0, 6, 7, 1, "R2");
    rdy_mode = 0;
    send_field(1, 1, 6, 6, 1, "R10");     // sub-res bottom: nothing
    send_field(0, 1, 6, 7, 1, "R11");     // sub-res top: even columns
    send_field(0, 0, 6, 10, 1, "R12");    // wider than MAX_W

    chk(lo_seen, "R8 low clip reached", lo_seen, 1);
    chk(hi_seen, "R8 high clip reached", hi_seen, 1);
    chk(exp_q.size() == 0, "R4 outputs missing", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule